// File: doc/BRIEF.md
# Accumulator Processor with Device Register Window

This block is a small 32-bit processor built around a single accumulator. It fetches instruction words from one shared code-and-data memory through a synchronous port, where read data appears one clock after the address. Constants can therefore sit inline in the program, with a jump placed before them so they are never executed. An instruction word carries an 8-bit opcode in bits [31:24] and a 24-bit direct address in bits [23:0]. Only four instructions do anything: load the accumulator, store the accumulator, jump, and stop.

A 64-word window at 0x080000 is routed to internal 32-bit configuration registers instead of the memory port. Sixteen sparse offsets in that window are backed by registers. These registers stand in for the settings of on-chip devices, and a program can write them and read them back. The processor drives out the accumulator and a halted flag so that a program's progress can be followed.

Top module: `acc_cpu`

## Requirements
- R1: While rst_ni is low, acc_o is 0, halted_o is 0, mem_we_o is 0 and mem_addr_o is 0. The first fetch after reset is from address 0.
- R2: Opcode 0x00 (bits [31:24]) loads the accumulator from the word at the address in bits [23:0].
- R3: Opcode 0x01 drives mem_addr_o to the address field, drives mem_wdata_o to the accumulator and pulses mem_we_o for one cycle, so memory receives the accumulator.
- R4: Opcode 0x04 loads the program counter with the address field. Words between the jump and its target are never executed.
- R5: Opcode 0x07 raises halted_o 3 clocks after its fetch cycle starts. From then until reset, halted_o stays high, mem_addr_o stays constant, mem_we_o stays low and acc_o is unchanged.
- R6: Addresses whose upper 18 bits equal those of 0x080000 belong to the register window. Registers exist at offsets 0x01-0x03, 0x08-0x0A, 0x10-0x12, 0x19-0x1B, 0x21-0x22 and 0x2A-0x2B. A load returns the value last stored at the same offset, and no store to the window reaches the memory port.
- R7: In the window, a load from an offset without a register returns 0. A store to such an offset changes no register and writes no memory.
- R8: Any other opcode (for example 0x02 or 0xFF) leaves the accumulator and memory unchanged and moves on to the next word.
- R9: Every instruction other than stop takes exactly 4 clocks: fetch, decode, execute and writeback. The next fetch address appears on mem_addr_o 4 clocks after the previous one.
- R10: After reset, every device register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 24 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 32 | Memory read data, one clock after the address |
| halted_o | output | 1 | Processor has executed stop |
| acc_o | output | 32 | Accumulator value |

## Verification
A corrupted program counter shows up on mem_addr_o at the next fetch, which is at most 4 clocks later. It also changes which stores reach memory, so the words left in memory reveal it. A wrong register index or a wrong window decode is hidden until the program loads that location and stores it back to memory. For that reason every device register is written before any of them is read back, so that aliasing between registers shows in the stored copies. Sequencer faults change the clock at which halted_o rises, and that clock is checked exactly.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;
  localparam int unsigned NUM_DEV_REGS = 16;

  localparam logic [7:0] OP_LDA = 8'h00;
  localparam logic [7:0] OP_STO = 8'h01;
  localparam logic [7:0] OP_JMP = 8'h04;
  localparam logic [7:0] OP_STP = 8'h07;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_WB, ST_HALT
  } state_e;

  // backed offsets inside the device window
  localparam logic [7:0] DEV_OFFS [NUM_DEV_REGS] = '{
    8'h01, 8'h02, 8'h03, 8'h08, 8'h09, 8'h0A, 8'h10, 8'h11,
    8'h12, 8'h19, 8'h1A, 8'h1B, 8'h21, 8'h22, 8'h2A, 8'h2B
  };
endpackage

// File: rtl/acc_cpu_addr_dec.sv
`timescale 1ns/1ps
module acc_cpu_addr_dec
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'h080000,
  parameter int unsigned WIN_BITS = 6,
  localparam int unsigned IDX_W   = $clog2(NUM_DEV_REGS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              win_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [NUM_DEV_REGS-1:0] match;

  assign win_o = (addr_i[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

  for (genvar g = 0; g < NUM_DEV_REGS; g++) begin : g_match
    assign match[g] = win_o && (addr_i[WIN_BITS-1:0] == DEV_OFFS[g][WIN_BITS-1:0]);
  end

  assign hit_o = |match;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_DEV_REGS; i++)
      if (match[i]) idx_o = IDX_W'(i);
  end

  always_comb assert (!hit_o || $onehot0(match)) else $error("p_onehot_match_r6");
endmodule

// File: rtl/acc_cpu_regwin.sv
`timescale 1ns/1ps
module acc_cpu_regwin
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NUM_DEV_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_DEV_REGS];

  for (genvar g = 0; g < NUM_DEV_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[g] <= '0;
      else if (we_i && hit_i && idx_i == IDX_W'(g)) regs_q[g] <= wdata_i;
    end

    p_reg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && hit_i && idx_i == IDX_W'(g)) |=> $stable(regs_q[g]));
  end

  assign rdata_o = hit_i ? regs_q[idx_i] : '0;
endmodule

// File: rtl/acc_cpu_core.sv
`timescale 1ns/1ps
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] opnd_o,
  input  logic              win_i,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              halted_o,
  output logic [DATA_W-1:0] acc_o
);
  localparam int unsigned OP_W = DATA_W - ADDR_W;

  state_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q, acc_q;
  logic [OP_W-1:0]   op;
  logic              is_sto;

  assign op     = ir_q[DATA_W-1:ADDR_W];
  assign opnd_o = ir_q[ADDR_W-1:0];
  assign is_sto = (state_q == ST_EXEC) && (op == OP_STO);

  assign mem_addr_o  = (state_q == ST_FETCH) ? pc_q : opnd_o;
  assign mem_wdata_o = acc_q;
  assign mem_we_o    = is_sto && !win_i;
  assign reg_we_o    = is_sto && win_i;
  assign halted_o    = (state_q == ST_HALT);
  assign acc_o       = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
    end else begin
      unique case (state_q)
        ST_FETCH:  state_q <= ST_DECODE;
        ST_DECODE: begin
          ir_q    <= mem_rdata_i;
          pc_q    <= pc_q + 1'b1;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (op == OP_JMP) pc_q <= opnd_o;
          state_q <= (op == OP_STP) ? ST_HALT : ST_WB;
        end
        ST_WB: begin
          if (op == OP_LDA) acc_q <= win_i ? reg_rdata_i : mem_rdata_i;
          state_q <= ST_FETCH;
        end
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_FETCH;
      endcase
    end
  end

  p_halt_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(pc_q) && $stable(mem_addr_o));
  p_halt_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o && !reg_we_o);
  p_pc_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECODE) |=> pc_q == $past(pc_q) + 1'b1);
  p_jump_target_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && op == OP_JMP) |=> pc_q == $past(opnd_o));
  p_acc_only_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_WB || op != OP_LDA) |=> $stable(acc_q));
endmodule

// File: rtl/acc_cpu.sv
`timescale 1ns/1ps
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'h080000,
  parameter int unsigned WIN_BITS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o,
  output logic [DATA_W-1:0] acc_o
);
  localparam int unsigned IDX_W = $clog2(NUM_DEV_REGS);

  logic [ADDR_W-1:0] opnd;
  logic              win, hit, reg_we;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] reg_rdata;

  acc_cpu_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk_i, .rst_ni, .mem_addr_o, .mem_wdata_o, .mem_we_o, .mem_rdata_i,
    .opnd_o(opnd), .win_i(win), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata),
    .halted_o, .acc_o
  );

  acc_cpu_addr_dec #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS)) u_dec (
    .addr_i(opnd), .win_o(win), .hit_o(hit), .idx_o(idx)
  );

  acc_cpu_regwin #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we), .hit_i(hit), .idx_i(idx),
    .wdata_i(mem_wdata_o), .rdata_o(reg_rdata)
  );

  p_no_window_mem_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[ADDR_W-1:WIN_BITS] != WIN_BASE[ADDR_W-1:WIN_BITS]);
endmodule

// File: tb/acc_cpu_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        mem_we, halted;
  logic [31:0] acc;

  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic        stray_clr = 1'b0;
  int          stray_wr;
  logic [31:0] mem [256];

  int n_checks = 0;
  int n_errors = 0;
  int pp;

  always #4 clk = ~clk;

  acc_cpu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .halted_o(halted), .acc_o(acc)
  );

  // synchronous memory model; writes outside the low 256 words are counted
  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we && mem_addr[23:8] == '0) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
    if (stray_clr) stray_wr <= 0;
    else if (mem_we && mem_addr[23:8] != '0) stray_wr <= stray_wr + 1;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 8'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic emit(input logic [7:0] op, input logic [23:0] a);
    poke(pp, {op, a});
    pp++;
  endtask

  task automatic prepare(input logic [31:0] fill);
    @(negedge clk);
    rst_n = 1'b0;
    stray_clr = 1'b1;
    for (int i = 0; i < 256; i++) poke(i, fill);
    stray_clr = 1'b0;
    pp = 0;
  endtask

  task automatic run_to_halt(input string req);
    int n;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(req, {31'd0, halted}, 32'd1);
  endtask

  task automatic t_reset;
    prepare(32'hDEAD);
    poke(8'h30, 32'h55);
    emit(8'h00, 24'h30);
    emit(8'h00, 24'h080001);
    emit(8'h01, 24'h40);
    emit(8'h00, 24'h08002B);
    emit(8'h01, 24'h41);
    emit(8'h07, 24'h0);
    @(negedge clk);
    check("R1 acc", acc, 32'h0);
    check("R1 halted", {31'd0, halted}, 32'h0);
    check("R1 we", {31'd0, mem_we}, 32'h0);
    check("R1 addr", {8'd0, mem_addr}, 32'h0);
    run_to_halt("R10 halt");
    check("R10 reg 080001 after reset", mem[8'h40], 32'h0);
    check("R10 reg 08002B after reset", mem[8'h41], 32'h0);
  endtask

  task automatic t_load_store;
    prepare(32'h0);
    poke(8'h20, 32'h1234_5678);
    emit(8'h00, 24'h20);
    emit(8'h01, 24'h21);
    emit(8'h07, 24'h0);
    run_to_halt("R2 halt");
    check("R2 acc", acc, 32'h1234_5678);
    check("R3 stored", mem[8'h21], 32'h1234_5678);
    check("R3 no stray", 32'(stray_wr), 32'h0);
  endtask

  task automatic t_jump;
    prepare(32'h0);
    poke(8'h10, 32'hCAFE_0001);
    emit(8'h00, 24'h10);
    emit(8'h04, 24'h4);
    emit(8'h01, 24'h30);   // skipped
    emit(8'h07, 24'h0);    // skipped
    emit(8'h01, 24'h31);
    emit(8'h07, 24'h0);
    run_to_halt("R4 halt");
    check("R4 skipped store", mem[8'h30], 32'h0);
    check("R4 target store", mem[8'h31], 32'hCAFE_0001);
  endtask

  task automatic t_timing;
    logic [23:0] a_halt;
    logic        saw_we;
    prepare(32'h0);
    poke(8'hC0, 32'h0000_0ABC);
    emit(8'h00, 24'hC0);
    emit(8'h07, 24'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 second fetch addr", {8'd0, mem_addr}, 32'h1);
    repeat (2) @(negedge clk);
    check("R5 not yet halted", {31'd0, halted}, 32'h0);
    @(negedge clk);
    check("R5 halted after 3 clocks", {31'd0, halted}, 32'h1);
    a_halt = mem_addr;
    saw_we = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      saw_we |= mem_we;
    end
    check("R5 stays halted", {31'd0, halted}, 32'h1);
    check("R5 addr frozen", {8'd0, mem_addr}, {8'd0, a_halt});
    check("R5 no write", {31'd0, saw_we}, 32'h0);
    check("R5 acc kept", acc, 32'h0000_0ABC);
  endtask

  task automatic t_regwin;
    logic [23:0] offs [16] = '{24'h01, 24'h02, 24'h03, 24'h08, 24'h09, 24'h0A, 24'h10, 24'h11,
                               24'h12, 24'h19, 24'h1A, 24'h1B, 24'h21, 24'h22, 24'h2A, 24'h2B};
    prepare(32'h0);
    for (int i = 0; i < 16; i++) poke(8'hC0 + i, 32'hA5A5_0000 + 32'(i * 3 + 1));
    for (int i = 0; i < 16; i++) begin
      emit(8'h00, 24'hC0 + 24'(i));
      emit(8'h01, 24'h080000 + offs[i]);
    end
    for (int i = 0; i < 16; i++) begin
      emit(8'h00, 24'h080000 + offs[i]);
      emit(8'h01, 24'h80 + 24'(i));
    end
    emit(8'h07, 24'h0);
    run_to_halt("R6 halt");
    for (int i = 0; i < 16; i++)
      check($sformatf("R6 reg offset %0h", offs[i]), mem[8'h80 + i], 32'hA5A5_0000 + 32'(i * 3 + 1));
    check("R6 no window write on port", 32'(stray_wr), 32'h0);
  endtask

  task automatic t_unmapped;
    prepare(32'h7777);
    poke(8'hC0, 32'hAAAA_5555);
    emit(8'h00, 24'hC0);
    emit(8'h01, 24'h080000);
    emit(8'h01, 24'h08003F);
    emit(8'h01, 24'h080004);
    emit(8'h00, 24'h080000);
    emit(8'h01, 24'h90);
    emit(8'h00, 24'hC0);
    emit(8'h00, 24'h080004);
    emit(8'h01, 24'h91);
    emit(8'h00, 24'h080003);
    emit(8'h01, 24'h92);
    emit(8'h07, 24'h0);
    run_to_halt("R7 halt");
    check("R7 load 080000", mem[8'h90], 32'h0);
    check("R7 load 080004", mem[8'h91], 32'h0);
    check("R7 neighbour 080003 untouched", mem[8'h92], 32'h0);
    check("R7 no memory write", 32'(stray_wr), 32'h0);
  endtask

  task automatic t_nop;
    prepare(32'h1111);
    poke(8'hC0, 32'h0BAD_F00D);
    emit(8'h00, 24'hC0);
    emit(8'h02, 24'h95);
    emit(8'hFF, 24'h96);
    emit(8'h01, 24'h97);
    emit(8'h07, 24'h0);
    run_to_halt("R8 halt");
    check("R8 op 02 no write", mem[8'h95], 32'h1111);
    check("R8 op FF no write", mem[8'h96], 32'h1111);
    check("R8 acc kept", mem[8'h97], 32'h0BAD_F00D);
    check("R8 acc port", acc, 32'h0BAD_F00D);
  endtask

  initial begin
    #(8 * 150000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_load_store();
    t_jump();
    t_timing();
    t_regwin();
    t_unmapped();
    t_nop();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule